// File: doc/BRIEF.md
# Processor Operating-Mode Summary Register

This block keeps one packed summary word that describes the processor's current operating mode. Decode and translation logic read this word instead of the raw control state. The word holds the mode and the submode, the current privilege level, the paging and protection enables, and the default and alternate operand and address sizes plus the stack size. Each size is a log2 byte count: 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes.

The block also holds the five source values the word depends on. These are the extended-feature word, control word 0, the code-segment attributes, the stack-segment attributes and the flags word. A single write port updates one source per cycle. Writes to control word 0 or to either segment attribute set recompute the summary from the freshly written value. A write addressed to the summary index recomputes it from the stored state and discards the bus data. A control-word-0 write that flips the paging bit while long mode is enabled also sets or clears the long-mode-active bit of the extended-feature word. The summary and the extended-feature word can be read back at all times.

Top module: `cpu_mode_summary`

## Requirements
- R1: When the long-mode-active bit (extended-feature bit 10) used by a recompute is 1, the mode field is 1. The submode is then 4 (64-bit) if the code-segment long bit (attribute bit 2) is 1, and 3 (compatibility) if it is 0.
- R2: When the long-mode-active bit is 0, the mode field is 0. The submode is then 0 (real) when control-word-0 bit 0 (protection enable) is clear. With protection enabled, the submode is 2 (virtual-8086) when flags bit 17 is set, and 1 (protected) otherwise.
- R3: The privilege field copies code-segment attribute bits 1:0. The paging field copies control-word-0 bit 31. The protection field copies control-word-0 bit 0.
- R4: The default/alternate operand sizes are 2/1 in 64-bit submode or when the code-segment default-size bit (attribute bit 3) is set. Otherwise they are 1/2.
- R5: The default/alternate address sizes are 3/2 in 64-bit submode. Outside 64-bit submode they are 2/1 when the code-segment default-size bit is set and 1/2 when it is clear.
- R6: The stack size is 3 in 64-bit submode. Otherwise it is 2 when the stack-segment default-size bit (attribute bit 3) is set, and 1 when it is clear.
- R7: A write to control word 0 (index 1) that changes bit 31 while extended-feature bit 8 (long-mode enable) is set copies the new bit 31 into extended-feature bit 10. Without such a change, or without the enable, bit 10 keeps its value. The recompute uses the updated bit 10.
- R8: Writes to control word 0 (index 1), code-segment attributes (index 2) or stack-segment attributes (index 3) recompute the summary using the newly written value. The new word is visible in the cycle after the write.
- R9: A write to the summary index (5) recomputes the word from the stored sources, and none of its data bits reach the word.
- R10: Writes to the extended-feature word (index 0) or the flags word (index 4) store the value without changing the summary. Writes to indices 6 and 7 change neither the summary nor the extended-feature word.
- R11: After a synchronous active-low reset, the summary word and all stored sources are zero.
- R12: Summary layout: mode bit 0, submode 3:1, privilege 5:4, paging 6, protection 7, default operand 9:8, alternate operand 11:10, default address 13:12, alternate address 15:14, stack 17:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index of the write |
| wr_data | input | DATA_W (32) | Write data |
| summary_q | output | 18 | Packed mode summary word |
| efer_q | output | DATA_W (32) | Stored extended-feature word |

## Verification
The summary word and the extended-feature readback are both registered once after the write port. Every result is therefore due exactly one clock after the edge that takes the write. The bench applies each write on a falling edge and holds it through one rising edge. It drops the strobe on the next falling edge and compares both outputs at that same point, one cycle after the write. For writes that must not recompute, the bench samples at the same one-cycle point and expects the earlier summary value.

// File: rtl/pmode_pkg.sv
// Package: shared encodings for the operating-mode summary block.
// Assumes a 3-bit register index and 2-bit log2 size fields.
package pmode_pkg;

    localparam int IDX_W  = 3;
    localparam int SIZE_W = 2;
    localparam int CPL_W  = 2;

    localparam logic [IDX_W-1:0] IDX_EFER    = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CR0     = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CS_ATTR = 3'd2;
    localparam logic [IDX_W-1:0] IDX_SS_ATTR = 3'd3;
    localparam logic [IDX_W-1:0] IDX_FLAGS   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_SUMMARY = 3'd5;

    typedef enum logic [2:0] {
        SUB_REAL   = 3'd0,
        SUB_PROT   = 3'd1,
        SUB_V86    = 3'd2,
        SUB_COMPAT = 3'd3,
        SUB_WIDE   = 3'd4
    } submode_e;

    // Segment attribute word: default size, long bit, privilege.
    typedef struct packed {
        logic             def_size;
        logic             long_seg;
        logic [CPL_W-1:0] dpl;
    } seg_attr_t;

    localparam int SEG_W = $bits(seg_attr_t);

    // Summary word; the first field is the most significant.
    typedef struct packed {
        logic [SIZE_W-1:0] stack_sz;
        logic [SIZE_W-1:0] alt_addr;
        logic [SIZE_W-1:0] def_addr;
        logic [SIZE_W-1:0] alt_op;
        logic [SIZE_W-1:0] def_op;
        logic              prot_en;
        logic              page_en;
        logic [CPL_W-1:0]  cpl;
        submode_e          submode;
        logic              long_mode;
    } summary_t;

    localparam int SUM_W = $bits(summary_t);

endpackage

// File: rtl/pmode_src_regs.sv
// Module: stores the source state the summary is built from, and
// provides the post-write (next) view of it for the recompute.
// Applies the paging-toggle side effect on the long-mode-active bit.
// Assumes only one register is written per cycle.
module pmode_src_regs
    import pmode_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LME_BIT = 8,
    parameter int LMA_BIT = 10,
    parameter int PE_BIT  = 0,
    parameter int PG_BIT  = 31,
    parameter int VM_BIT  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] efer_q,
    output logic              lma_nx,
    output logic              pe_nx,
    output logic              pg_nx,
    output logic              vm_nx,
    output seg_attr_t         cs_nx,
    output logic              ss_def_nx
);

    logic [DATA_W-1:0] efer_nx;
    logic              pe_q, pg_q, vm_q, ss_def_q;
    seg_attr_t         cs_q;

    // Merge the current write into the stored state.
    always_comb begin
        efer_nx   = efer_q;
        pe_nx     = pe_q;
        pg_nx     = pg_q;
        vm_nx     = vm_q;
        cs_nx     = cs_q;
        ss_def_nx = ss_def_q;
        if (wr_en) begin
            case (wr_sel)
                IDX_EFER: efer_nx = wr_data;
                IDX_CR0: begin
                    pe_nx = wr_data[PE_BIT];
                    pg_nx = wr_data[PG_BIT];
                    if (efer_q[LME_BIT] && (pg_q != wr_data[PG_BIT]))
                        efer_nx[LMA_BIT] = wr_data[PG_BIT];
                end
                IDX_CS_ATTR: cs_nx = seg_attr_t'(wr_data[SEG_W-1:0]);
                IDX_SS_ATTR: ss_def_nx = wr_data[SEG_W-1];
                IDX_FLAGS:   vm_nx = wr_data[VM_BIT];
                default: ;
            endcase
        end
    end

    assign lma_nx = efer_nx[LMA_BIT];

    // Hold the source state; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            efer_q   <= '0;
            pe_q     <= 1'b0;
            pg_q     <= 1'b0;
            vm_q     <= 1'b0;
            cs_q     <= '0;
            ss_def_q <= 1'b0;
        end else begin
            efer_q   <= efer_nx;
            pe_q     <= pe_nx;
            pg_q     <= pg_nx;
            vm_q     <= vm_nx;
            cs_q     <= cs_nx;
            ss_def_q <= ss_def_nx;
        end
    end

    AST_LMA_FOLLOWS_PG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == IDX_CR0 && efer_q[LME_BIT] && (pg_q != wr_data[PG_BIT]))
        |=> efer_q[LMA_BIT] == $past(wr_data[PG_BIT])); // R7

    AST_LMA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == IDX_CR0 && !efer_q[LME_BIT])
        |=> $stable(efer_q)); // R7

endmodule

// File: rtl/pmode_classify.sv
// Module: derives the mode and submode from the post-write sources.
// Purely combinational; the caller registers the result.
module pmode_classify
    import pmode_pkg::*;
(
    input  logic     lma,
    input  logic     pe,
    input  logic     vm,
    input  logic     cs_long,
    output logic     long_mode,
    output submode_e submode
);

    // Pick mode first, then the submode within it.
    always_comb begin
        if (lma) begin
            long_mode = 1'b1;
            submode   = cs_long ? SUB_WIDE : SUB_COMPAT;
        end else begin
            long_mode = 1'b0;
            if (!pe)
                submode = SUB_REAL;
            else if (vm)
                submode = SUB_V86;
            else
                submode = SUB_PROT;
        end
    end

endmodule

// File: rtl/pmode_size_derive.sv
// Module: derives operand, address and stack log2 sizes from the
// submode and the two segment default-size bits. Combinational.
module pmode_size_derive
    import pmode_pkg::*;
(
    input  submode_e          submode,
    input  logic              cs_def,
    input  logic              ss_def,
    output logic [SIZE_W-1:0] def_op,
    output logic [SIZE_W-1:0] alt_op,
    output logic [SIZE_W-1:0] def_addr,
    output logic [SIZE_W-1:0] alt_addr,
    output logic [SIZE_W-1:0] stack_sz
);

    localparam logic [SIZE_W-1:0] SZ2 = SIZE_W'(1);
    localparam logic [SIZE_W-1:0] SZ4 = SIZE_W'(2);
    localparam logic [SIZE_W-1:0] SZ8 = SIZE_W'(3);

    logic wide;
    assign wide = (submode == SUB_WIDE);

    // Operand sizes: 4-byte default for wide code or 32-bit segments.
    always_comb begin
        if (wide || cs_def) begin
            def_op = SZ4;
            alt_op = SZ2;
        end else begin
            def_op = SZ2;
            alt_op = SZ4;
        end
    end

    // Address sizes: 8-byte default only in the wide submode.
    always_comb begin
        if (wide) begin
            def_addr = SZ8;
            alt_addr = SZ4;
        end else if (cs_def) begin
            def_addr = SZ4;
            alt_addr = SZ2;
        end else begin
            def_addr = SZ2;
            alt_addr = SZ4;
        end
    end

    // Stack size follows the stack segment outside the wide submode.
    always_comb begin
        if (wide)
            stack_sz = SZ8;
        else if (ss_def)
            stack_sz = SZ4;
        else
            stack_sz = SZ2;
    end

endmodule

// File: rtl/cpu_mode_summary.sv
// Module: top of the operating-mode summary block. Holds the source
// registers, recomputes the packed summary on the writes that affect
// it, and exposes the summary and extended-feature word for reading.
// Assumes writes arrive one per cycle on a single port.
module cpu_mode_summary
    import pmode_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LME_BIT = 8,
    parameter int LMA_BIT = 10,
    parameter int PE_BIT  = 0,
    parameter int PG_BIT  = 31,
    parameter int VM_BIT  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SUM_W-1:0]  summary_q,
    output logic [DATA_W-1:0] efer_q
);

    logic      lma_nx, pe_nx, pg_nx, vm_nx, ss_def_nx;
    seg_attr_t cs_nx;
    logic      long_mode;
    submode_e  submode;
    logic [SIZE_W-1:0] def_op, alt_op, def_addr, alt_addr, stack_sz;
    summary_t  summary_nx, summary_r;
    logic      recompute;

    pmode_src_regs #(
        .DATA_W(DATA_W), .LME_BIT(LME_BIT), .LMA_BIT(LMA_BIT),
        .PE_BIT(PE_BIT), .PG_BIT(PG_BIT), .VM_BIT(VM_BIT)
    ) src_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .efer_q(efer_q), .lma_nx(lma_nx),
        .pe_nx(pe_nx), .pg_nx(pg_nx), .vm_nx(vm_nx), .cs_nx(cs_nx),
        .ss_def_nx(ss_def_nx)
    );

    pmode_classify cls_i (
        .lma(lma_nx), .pe(pe_nx), .vm(vm_nx), .cs_long(cs_nx.long_seg),
        .long_mode(long_mode), .submode(submode)
    );

    pmode_size_derive siz_i (
        .submode(submode), .cs_def(cs_nx.def_size), .ss_def(ss_def_nx),
        .def_op(def_op), .alt_op(alt_op), .def_addr(def_addr),
        .alt_addr(alt_addr), .stack_sz(stack_sz)
    );

    // Writes that refresh the summary.
    always_comb begin
        recompute = 1'b0;
        if (wr_en) begin
            case (wr_sel)
                IDX_CR0, IDX_CS_ATTR, IDX_SS_ATTR, IDX_SUMMARY: recompute = 1'b1;
                default: recompute = 1'b0;
            endcase
        end
    end

    // Assemble the candidate summary word.
    always_comb begin
        summary_nx.long_mode = long_mode;
        summary_nx.submode   = submode;
        summary_nx.cpl       = cs_nx.dpl;
        summary_nx.page_en   = pg_nx;
        summary_nx.prot_en   = pe_nx;
        summary_nx.def_op    = def_op;
        summary_nx.alt_op    = alt_op;
        summary_nx.def_addr  = def_addr;
        summary_nx.alt_addr  = alt_addr;
        summary_nx.stack_sz  = stack_sz;
    end

    // Summary register: zero on reset, loaded only on a recompute.
    always_ff @(posedge clk) begin
        if (!rst_n)
            summary_r <= '0;
        else if (recompute)
            summary_r <= summary_nx;
    end

    assign summary_q = summary_r;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (summary_q == '0 && efer_q == '0)); // R11

    AST_SUMMARY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == IDX_EFER || wr_sel == IDX_FLAGS || wr_sel > IDX_SUMMARY))
        |=> $stable(summary_q)); // R10

    AST_LONG_SUBMODE: assert property (@(posedge clk) disable iff (!rst_n)
        summary_r.long_mode |-> (summary_r.submode == SUB_WIDE ||
                                 summary_r.submode == SUB_COMPAT)); // R1

    AST_LEGACY_SUBMODE: assert property (@(posedge clk) disable iff (!rst_n)
        !summary_r.long_mode |-> (summary_r.submode == SUB_REAL ||
                                  summary_r.submode == SUB_PROT ||
                                  summary_r.submode == SUB_V86)); // R2

    AST_WIDE_SIZES: assert property (@(posedge clk) disable iff (!rst_n)
        (summary_r.submode == SUB_WIDE) |-> (summary_r.def_addr == 2'd3 &&
            summary_r.stack_sz == 2'd3 && summary_r.def_op == 2'd2)); // R5

    AST_CPL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == IDX_CS_ATTR)
        |=> summary_r.cpl == $past(wr_data[CPL_W-1:0])); // R8

endmodule

// File: tb/cpu_mode_summary_tb_top.sv
module cpu_mode_summary_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [17:0] summary_q;
    logic [31:0] efer_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    cpu_mode_summary dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .summary_q(summary_q), .efer_q(efer_q)
    );

    // Stimulus {lma,pe,pg,vm,cs_long,cs_def,dpl[1:0],ss_def} and expected
    // summary {stack,altAddr,defAddr,altOp,defOp,prot,pg,cpl,sub,mode}.
    localparam int NVEC = 8;
    localparam logic [26:0] VEC [NVEC] = '{
        {9'b0_0_0_0_0_0_00_0, 2'd1,2'd2,2'd1,2'd2,2'd1,1'b0,1'b0,2'd0,3'd0,1'b0},
        {9'b0_1_0_0_0_1_00_1, 2'd2,2'd1,2'd2,2'd1,2'd2,1'b1,1'b0,2'd0,3'd1,1'b0},
        {9'b0_1_1_1_0_0_11_0, 2'd1,2'd2,2'd1,2'd2,2'd1,1'b1,1'b1,2'd3,3'd2,1'b0},
        {9'b1_1_1_0_1_0_00_0, 2'd3,2'd2,2'd3,2'd1,2'd2,1'b1,1'b1,2'd0,3'd4,1'b1},
        {9'b1_1_1_0_0_1_11_1, 2'd2,2'd1,2'd2,2'd1,2'd2,1'b1,1'b1,2'd3,3'd3,1'b1},
        {9'b1_1_1_0_0_0_01_0, 2'd1,2'd2,2'd1,2'd2,2'd1,1'b1,1'b1,2'd1,3'd3,1'b1},
        {9'b0_0_0_1_0_1_10_1, 2'd2,2'd1,2'd2,2'd1,2'd2,1'b0,1'b0,2'd2,3'd0,1'b0},
        {9'b1_1_1_1_1_1_10_1, 2'd3,2'd2,2'd3,2'd1,2'd2,1'b1,1'b1,2'd2,3'd4,1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        // R11: reset state
        do_reset();
        chk("R11 summary after reset", 32'(summary_q), 32'h0);
        chk("R11 efer after reset", efer_q, 32'h0);

        // Table walk: R1 R2 R3 R4 R5 R6 R8 R12
        for (int i = 0; i < NVEC; i++) begin
            logic [8:0]  s;
            logic [17:0] e;
            s = VEC[i][26:18];
            e = VEC[i][17:0];
            wr(3'd0, {21'd0, s[8], 10'd0});
            wr(3'd4, {14'd0, s[5], 17'd0});
            wr(3'd1, {s[6], 30'd0, s[7]});
            wr(3'd2, {28'd0, s[3], s[4], s[2:1]});
            wr(3'd3, {28'd0, s[0], 3'b000});
            chk($sformatf("R1 R2 R3 R4 R5 R6 R12 vector %0d", i), 32'(summary_q), 32'(e));
            chk($sformatf("R8 efer vector %0d", i), efer_q, {21'd0, s[8], 10'd0});
        end

        // R7: paging toggle with long-mode enable activates long mode
        do_reset();
        wr(3'd0, 32'h0000_0100);
        wr(3'd1, 32'h8000_0001);
        chk("R7 lma set on pg rise", efer_q, 32'h0000_0500);
        chk("R7 summary uses new lma",
            32'(summary_q), 32'({2'd1,2'd2,2'd1,2'd2,2'd1,1'b1,1'b1,2'd0,3'd3,1'b1}));
        wr(3'd1, 32'h8000_0001);
        chk("R7 no toggle keeps lma", efer_q, 32'h0000_0500);
        wr(3'd1, 32'h0000_0001);
        chk("R7 lma cleared on pg fall", efer_q, 32'h0000_0100);
        chk("R7 summary legacy protected",
            32'(summary_q), 32'({2'd1,2'd2,2'd1,2'd2,2'd1,1'b1,1'b0,2'd0,3'd1,1'b0}));

        // R7: no enable, no side effect
        do_reset();
        wr(3'd1, 32'h8000_0001);
        chk("R7 lma untouched without enable", efer_q, 32'h0);

        // R10: writes that must not recompute
        do_reset();
        wr(3'd0, 32'h0000_0400);
        chk("R10 efer stored", efer_q, 32'h0000_0400);
        chk("R10 efer write leaves summary", 32'(summary_q), 32'h0);
        wr(3'd4, 32'h0002_0000);
        chk("R10 flags write leaves summary", 32'(summary_q), 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        chk("R10 unused index leaves summary", 32'(summary_q), 32'h0);
        chk("R10 unused index leaves efer", efer_q, 32'h0000_0400);

        // R9: summary-index write recomputes, data discarded
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R9 recompute from stored state",
            32'(summary_q), 32'({2'd1,2'd2,2'd1,2'd2,2'd1,1'b0,1'b0,2'd0,3'd3,1'b1}));

        // R8: code-segment write recomputes with new value
        wr(3'd2, 32'h0000_0007);
        chk("R8 cs write recompute",
            32'(summary_q), 32'({2'd3,2'd2,2'd3,2'd1,2'd2,1'b0,1'b0,2'd3,3'd4,1'b1}));

        // R6: stack segment ignored in wide submode
        wr(3'd3, 32'h0000_0008);
        chk("R6 stack stays 8 bytes in wide submode", 32'(summary_q[17:16]), 32'd3);

        finish_run();
    end

endmodule